// File: doc/BRIEF.md
# Sun Tracker Mode Controller

This controller decides how an image sensor is read out while a sun sensor looks for the sun and then follows it. It has two modes. In search mode it requests the whole 512 x 512 pixel array on every frame. In follow mode it requests only an 80 x 80 window placed around the last sun fix. Each mode has its own frame period, set in clock cycles. A free-running timer raises a frame tick, and every accepted tick issues exactly one readout command. The command carries the window origin and the window size.

The detection pipeline returns one result per frame. The result says whether a sun was found and, if so, gives its X and Y position as 16-bit coordinates with 6 fractional bits, so that one pixel equals 64 counts. A find in search mode moves the controller to follow mode. A run of misses in follow mode returns it to search mode and marks the reported position invalid. The busy output is high from a command until its result arrives. Downstream logic can stop the readout and processing clocks while it is low.

Top module: `sun_track_ctrl`

## Requirements
- R1: While reset is held, and after it, the controller is in search mode (track_o=0), busy_o=0, pos_valid_o=0 and cmd_valid_o=0.
- R2: A search-mode command has origin (0,0) and size 512 x 512.
- R3: A follow-mode command has size 80 x 80. On each axis its origin is the pixel index of the held position (position >> 6) minus 40, clamped to the range 0 to 432.
- R4: A found result in search mode stores res_x_i/res_y_i unchanged into pos_x_o/pos_y_o. pos_valid_o goes high one cycle after the result, and the next frame runs in follow mode.
- R5: In follow mode a found result updates the position and clears the miss count. After miss_lim_i consecutive misses (0 acts as 1), pos_valid_o drops, the next frame runs in search mode and the position is held. Fewer misses keep follow mode and the held position.
- R6: track_o and the window origin change only in the cycle that cmd_valid_o is high. A mode change decided by a result takes effect at the next command.
- R7: Consecutive commands are spaced by acq_per_i cycles after a search frame and by trk_per_i cycles after a follow frame. Values below 2 act as 2.
- R8: busy_o rises together with cmd_valid_o and stays high until a result is accepted. It is low at all other times.
- R9: A frame tick that comes while busy_o is high is dropped. No command is issued until a result is accepted and a later tick arrives.
- R10: A result offered while busy_o is low is ignored and changes neither mode nor position.
- R11: A miss in search mode keeps search mode and leaves pos_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_per_i | input | TW | Frame period in search mode, in cycles |
| trk_per_i | input | TW | Frame period in follow mode, in cycles |
| miss_lim_i | input | MW | Consecutive follow-mode misses before falling back |
| res_valid_i | input | 1 | Per-frame detection result strobe |
| res_found_i | input | 1 | A sun was found in this frame |
| res_x_i | input | CW | Sun X position, 6 fractional bits |
| res_y_i | input | CW | Sun Y position, 6 fractional bits |
| frame_tick_o | output | 1 | One-cycle pulse at every timer frame boundary |
| cmd_valid_o | output | 1 | Readout command strobe |
| cmd_x_o | output | AW | Window origin column |
| cmd_y_o | output | AW | Window origin row |
| cmd_w_o | output | AW | Window width |
| cmd_h_o | output | AW | Window height |
| track_o | output | 1 | 1 = follow mode, 0 = search mode |
| busy_o | output | 1 | Readout/processing active; low means clocks may stop |
| pos_valid_o | output | 1 | Reported position is valid |
| pos_x_o | output | CW | Reported sun X |
| pos_y_o | output | CW | Reported sun Y |

## Verification
The hardest situation to reach is a frame tick that lands while a frame is still open. A result normally comes back within a few cycles, long before the next tick. To force the overlap, the stimulus holds the result back for three whole follow-mode periods. During that time the bench counts command pulses and watches busy_o. The window clamp is driven to both edges on both axes, and the fallback is reached through a run of misses with two different limits.

// File: rtl/sun_track_pkg.sv
package sun_track_pkg;
  typedef enum logic {
    MODE_SEARCH = 1'b0,
    MODE_FOLLOW = 1'b1
  } track_mode_e;
endpackage

// File: rtl/stc_frame_timer.sv
module stc_frame_timer #(
  parameter int TW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] period_i,
  output logic          tick_o
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] per_q;
  logic [TW-1:0] eff_per;

  assign eff_per = (per_q < TW'(2)) ? TW'(2) : per_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      tick_o <= 1'b0;
    end else if (cnt_q >= eff_per - TW'(1)) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + TW'(1);
      tick_o <= 1'b0;
    end
  end

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < eff_per);
endmodule

// File: rtl/stc_win_place.sv
module stc_win_place #(
  parameter int CW   = 16,
  parameter int FRAC = 6,
  parameter int ARR  = 512,
  parameter int WIN  = 80,
  parameter int AW   = 10
) (
  input  logic [CW-1:0] pos_i,
  output logic [AW-1:0] org_o
);
  localparam int HALF = WIN / 2;
  localparam int MAXO = ARR - WIN;

  logic [CW-1:0] pix;
  logic [CW-1:0] diff;

  always_comb begin
    pix  = pos_i >> FRAC;
    diff = pix - CW'(HALF);
    if (pix < CW'(HALF))
      org_o = '0;
    else if (diff > CW'(MAXO))
      org_o = AW'(MAXO);
    else
      org_o = diff[AW-1:0];
  end
endmodule

// File: rtl/stc_mode_seq.sv
module stc_mode_seq
  import sun_track_pkg::*;
#(
  parameter int CW  = 16,
  parameter int ARR = 512,
  parameter int WIN = 80,
  parameter int AW  = 10,
  parameter int MW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic [MW-1:0] miss_lim_i,
  input  logic          res_valid_i,
  input  logic          res_found_i,
  input  logic [CW-1:0] res_x_i,
  input  logic [CW-1:0] res_y_i,
  input  logic [AW-1:0] org_x_i,
  input  logic [AW-1:0] org_y_i,
  output logic          next_follow_o,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_x_o,
  output logic [AW-1:0] cmd_y_o,
  output logic [AW-1:0] cmd_w_o,
  output logic [AW-1:0] cmd_h_o,
  output logic          track_o,
  output logic          busy_o,
  output logic          pos_valid_o,
  output logic [CW-1:0] pos_x_o,
  output logic [CW-1:0] pos_y_o
);
  track_mode_e   mode_q, mode_nx_q;
  logic [MW-1:0] miss_q;
  logic [MW-1:0] lim_eff;

  assign lim_eff       = (miss_lim_i == '0) ? MW'(1) : miss_lim_i;
  assign next_follow_o = (mode_nx_q == MODE_FOLLOW);
  assign track_o       = (mode_q == MODE_FOLLOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_SEARCH;
      mode_nx_q   <= MODE_SEARCH;
      busy_o      <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_x_o     <= '0;
      cmd_y_o     <= '0;
      cmd_w_o     <= '0;
      cmd_h_o     <= '0;
      pos_valid_o <= 1'b0;
      pos_x_o     <= '0;
      pos_y_o     <= '0;
      miss_q      <= '0;
    end else begin
      cmd_valid_o <= 1'b0;
      if (tick_i && !busy_o) begin
        busy_o      <= 1'b1;
        cmd_valid_o <= 1'b1;
        mode_q      <= mode_nx_q;
        if (mode_nx_q == MODE_FOLLOW) begin
          cmd_x_o <= org_x_i;
          cmd_y_o <= org_y_i;
          cmd_w_o <= AW'(WIN);
          cmd_h_o <= AW'(WIN);
        end else begin
          cmd_x_o <= '0;
          cmd_y_o <= '0;
          cmd_w_o <= AW'(ARR);
          cmd_h_o <= AW'(ARR);
        end
      end else if (busy_o && res_valid_i) begin
        busy_o <= 1'b0;
        if (res_found_i) begin
          pos_x_o     <= res_x_i;
          pos_y_o     <= res_y_i;
          pos_valid_o <= 1'b1;
          mode_nx_q   <= MODE_FOLLOW;
          miss_q      <= '0;
        end else if (mode_q == MODE_FOLLOW) begin
          if (miss_q + MW'(1) >= lim_eff) begin
            mode_nx_q   <= MODE_SEARCH;
            pos_valid_o <= 1'b0;
            miss_q      <= '0;
          end else begin
            miss_q <= miss_q + MW'(1);
          end
        end
      end
    end
  end

  // R8
  cmd_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> busy_o);

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid_o |-> ($stable(track_o) && $stable(cmd_x_o) && $stable(cmd_y_o)));

  // R3
  win_inside_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && track_o) |->
      (cmd_w_o == AW'(WIN) && cmd_x_o <= AW'(ARR - WIN) && cmd_y_o <= AW'(ARR - WIN)));

  // R5
  pv_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pos_valid_o) |-> $past(res_valid_i && !res_found_i && busy_o));

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !res_valid_i) |=> !cmd_valid_o);
endmodule

// File: rtl/sun_track_ctrl.sv
module sun_track_ctrl
  import sun_track_pkg::*;
#(
  parameter int ARR  = 512,
  parameter int WIN  = 80,
  parameter int CW   = 16,
  parameter int FRAC = 6,
  parameter int TW   = 20,
  parameter int MW   = 8,
  parameter int AW   = $clog2(ARR + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] acq_per_i,
  input  logic [TW-1:0] trk_per_i,
  input  logic [MW-1:0] miss_lim_i,
  input  logic          res_valid_i,
  input  logic          res_found_i,
  input  logic [CW-1:0] res_x_i,
  input  logic [CW-1:0] res_y_i,
  output logic          frame_tick_o,
  output logic          cmd_valid_o,
  output logic [AW-1:0] cmd_x_o,
  output logic [AW-1:0] cmd_y_o,
  output logic [AW-1:0] cmd_w_o,
  output logic [AW-1:0] cmd_h_o,
  output logic          track_o,
  output logic          busy_o,
  output logic          pos_valid_o,
  output logic [CW-1:0] pos_x_o,
  output logic [CW-1:0] pos_y_o
);
  logic          next_follow;
  logic [TW-1:0] period_sel;
  logic [CW-1:0] pos_ax [2];
  logic [AW-1:0] org_ax [2];

  assign period_sel = next_follow ? trk_per_i : acq_per_i;
  assign pos_ax[0]  = pos_x_o;
  assign pos_ax[1]  = pos_y_o;

  stc_frame_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .period_i (period_sel),
    .tick_o   (frame_tick_o)
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    stc_win_place #(
      .CW(CW), .FRAC(FRAC), .ARR(ARR), .WIN(WIN), .AW(AW)
    ) u_place (
      .pos_i (pos_ax[a]),
      .org_o (org_ax[a])
    );
  end

  stc_mode_seq #(
    .CW(CW), .ARR(ARR), .WIN(WIN), .AW(AW), .MW(MW)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (frame_tick_o),
    .miss_lim_i    (miss_lim_i),
    .res_valid_i   (res_valid_i),
    .res_found_i   (res_found_i),
    .res_x_i       (res_x_i),
    .res_y_i       (res_y_i),
    .org_x_i       (org_ax[0]),
    .org_y_i       (org_ax[1]),
    .next_follow_o (next_follow),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_x_o       (cmd_x_o),
    .cmd_y_o       (cmd_y_o),
    .cmd_w_o       (cmd_w_o),
    .cmd_h_o       (cmd_h_o),
    .track_o       (track_o),
    .busy_o        (busy_o),
    .pos_valid_o   (pos_valid_o),
    .pos_x_o       (pos_x_o),
    .pos_y_o       (pos_y_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_valid_o && !busy_o && !pos_valid_o && !track_o));
endmodule

// File: tb/sun_track_ctrl_tb.sv
module sun_track_ctrl_tb;
  localparam int ACQ_P = 40;
  localparam int TRK_P = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] acq_per_i = 20'(ACQ_P);
  logic [19:0] trk_per_i = 20'(TRK_P);
  logic [7:0]  miss_lim_i = 8'd3;
  logic        res_valid_i = 1'b0, res_found_i = 1'b0;
  logic [15:0] res_x_i = '0, res_y_i = '0;
  logic        frame_tick_o, cmd_valid_o, track_o, busy_o, pos_valid_o;
  logic [9:0]  cmd_x_o, cmd_y_o, cmd_w_o, cmd_h_o;
  logic [15:0] pos_x_o, pos_y_o;

  int nchk = 0, nerr = 0, cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sun_track_ctrl u_dut (
    .clk(clk), .rst(rst), .acq_per_i(acq_per_i), .trk_per_i(trk_per_i),
    .miss_lim_i(miss_lim_i), .res_valid_i(res_valid_i), .res_found_i(res_found_i),
    .res_x_i(res_x_i), .res_y_i(res_y_i), .frame_tick_o(frame_tick_o),
    .cmd_valid_o(cmd_valid_o), .cmd_x_o(cmd_x_o), .cmd_y_o(cmd_y_o),
    .cmd_w_o(cmd_w_o), .cmd_h_o(cmd_h_o), .track_o(track_o), .busy_o(busy_o),
    .pos_valid_o(pos_valid_o), .pos_x_o(pos_x_o), .pos_y_o(pos_y_o)
  );

  // {found, rx, ry, exp_follow, exp_x, exp_y, exp_pos_valid_after}
  localparam logic [42:0] VEC [14] = '{
    {1'b1, 10'd100, 10'd200, 1'b0, 10'd0,   10'd0,   1'b1},
    {1'b1, 10'd10,  10'd500, 1'b1, 10'd60,  10'd160, 1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd0,   10'd432, 1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd0,   10'd432, 1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd0,   10'd432, 1'b0},
    {1'b1, 10'd472, 10'd40,  1'b0, 10'd0,   10'd0,   1'b1},
    {1'b1, 10'd300, 10'd41,  1'b1, 10'd432, 10'd0,   1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd260, 10'd1,   1'b1},
    {1'b1, 10'd41,  10'd300, 1'b1, 10'd260, 10'd1,   1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd1,   10'd260, 1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd1,   10'd260, 1'b1},
    {1'b0, 10'd0,   10'd0,   1'b1, 10'd1,   10'd260, 1'b0},
    {1'b0, 10'd0,   10'd0,   1'b0, 10'd0,   10'd0,   1'b0},
    {1'b0, 10'd0,   10'd0,   1'b0, 10'd0,   10'd0,   1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cmd();
    int n = 0;
    @(negedge clk);
    while (!cmd_valid_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R7 command issued", int'(cmd_valid_o), 1);
  endtask

  task automatic send(input logic f, input logic [15:0] x, input logic [15:0] y);
    res_valid_i = 1'b1; res_found_i = f; res_x_i = x; res_y_i = y;
    @(negedge clk);
    res_valid_i = 1'b0; res_found_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int t1;
    int t2;
    int npulse;
    int busy_low;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 track", int'(track_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 pos_valid", int'(pos_valid_o), 0);
    chk("R1 cmd_valid", int'(cmd_valid_o), 0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      logic [42:0] v;
      logic [15:0] px;
      logic [15:0] py;
      int ew;
      v = VEC[i];
      px = {v[41:32], 6'd37};
      py = {v[31:22], 6'd5};
      ew = v[21] ? 80 : 512;
      wait_cmd();
      chk(v[21] ? "R6 mode at command" : "R11 mode at command", int'(track_o), int'(v[21]));
      chk(v[21] ? "R3 origin x" : "R2 origin x", int'(cmd_x_o), int'(v[20:11]));
      chk(v[21] ? "R3 origin y" : "R2 origin y", int'(cmd_y_o), int'(v[10:1]));
      chk(v[21] ? "R3 width" : "R2 width", int'(cmd_w_o), ew);
      chk(v[21] ? "R3 height" : "R2 height", int'(cmd_h_o), ew);
      chk("R8 busy during frame", int'(busy_o), 1);
      repeat (2) @(negedge clk);
      send(v[42], px, py);
      chk("R5 pos_valid after result", int'(pos_valid_o), int'(v[0]));
      chk("R8 idle after result", int'(busy_o), 0);
      chk("R6 mode held until next command", int'(track_o), int'(v[21]));
      if (v[42]) begin
        chk("R4 pos x", int'(pos_x_o), int'(px));
        chk("R4 pos y", int'(pos_y_o), int'(py));
      end
    end

    // R10: result while idle is ignored (now in search mode, no fix)
    @(negedge clk);
    send(1'b1, 16'd12800, 16'd12800);
    wait_cmd();
    t1 = cyc;
    chk("R10 mode unchanged", int'(track_o), 0);
    chk("R10 pos_valid unchanged", int'(pos_valid_o), 0);

    // R7: search-frame spacing
    repeat (2) @(negedge clk);
    send(1'b0, 16'd0, 16'd0);
    wait_cmd();
    t2 = cyc;
    chk("R7 search period", t2 - t1, ACQ_P);
    chk("R11 stays search after miss", int'(track_o), 0);

    // go to follow, then measure follow spacing
    repeat (2) @(negedge clk);
    send(1'b1, 16'd6400, 16'd6400);
    wait_cmd();
    t1 = cyc;
    chk("R4 follow after find", int'(track_o), 1);
    repeat (2) @(negedge clk);
    send(1'b1, 16'd6400, 16'd6400);
    wait_cmd();
    t2 = cyc;
    chk("R7 follow period", t2 - t1, TRK_P);

    // R9: hold the result back for three periods
    npulse = 0;
    busy_low = 0;
    for (int k = 0; k < 3 * TRK_P; k++) begin
      @(negedge clk);
      if (cmd_valid_o) npulse++;
      if (!busy_o) busy_low++;
    end
    chk("R9 no command while busy", npulse, 0);
    chk("R9 busy held while waiting", busy_low, 0);
    send(1'b1, 16'd6400, 16'd6400);
    wait_cmd();
    chk("R9 follow resumes", int'(track_o), 1);

    // R5: limit 0 acts as 1
    miss_lim_i = 8'd0;
    repeat (2) @(negedge clk);
    send(1'b0, 16'd0, 16'd0);
    chk("R5 limit zero drops fix", int'(pos_valid_o), 0);
    chk("R5 position held", int'(pos_x_o), 6400);
    wait_cmd();
    chk("R5 back to search", int'(track_o), 0);
    chk("R2 width after fallback", int'(cmd_w_o), 512);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule